// File: doc/BRIEF.md
# Ethernet MAC control register bank

This block is the host-facing register bank of a legacy 16-bit Ethernet MAC. The host presents a register index together with a write strobe and write data, or a read strobe, and receives registered read data. Writes are not uniform across the map. Some registers keep only certain bits. Some accept writes only while the controller sits in reset mode. The tally counters store the inverse of what is written. The interrupt status bits clear when a one is written to them, and several registers cannot be written at all.

Writes to the command register are turned into one-cycle action pulses for the transmit, receive, timer and DMA engines, which sit outside this block. Most command bits also remain visible as state. The resource-read action is handled inside the bank: it advances the receive-resource read pointer, wraps it at the end of the resource area, and raises the buffers-exhausted status bit when the read pointer reaches the write pointer. Address-filter entries are loaded through a side port. The host can read them back 16 bits at a time through three read-only ports, but only while in reset mode. The interrupt line is the OR of the status bits that are enabled in the mask register.

Top module: `enet_regbank`

## Requirements
- R1: After reset, index 0 (command) reads 0x0094, index 18 (revision) reads 0x0004, index 5 (interrupt mask) and every other register read 0, and irq is low.
- R2: Index 1 (data configuration, mask 0xBFFF) and index 2 (second configuration, mask 0xF017) take a write only while command bit 7 (reset mode) is set. At other times the write leaves them unchanged.
- R3: Index 3 (receive control) keeps write data ANDed with 0xFFE0. Index 4 (transmit control) keeps data ANDed with 0xF000. Index 5 (interrupt mask) keeps data ANDed with 0x7FFF.
- R4: Index 6 (interrupt status) clears each bit written as one that is currently set. Input stat_set sets bits 14:0 and wins over a clear of the same bit in the same cycle. irq equals the OR of status AND mask, and it changes together with those registers.
- R5: Indices 7 (resource start), 8 (resource end), 9 (read pointer) and 10 (write pointer) store data ANDed with 0xFFFC when data configuration bit 5 (32-bit width) is set, and ANDed with 0xFFFE otherwise.
- R6: Indices 11, 12 and 13 (CRC-error, alignment-error and missed-packet tallies) store the bitwise inverse of the written data.
- R7: Indices 15 to 19 ignore writes. Index 18 reads 0x0004 and index 19 reads 0. Index 15+k (k = 0, 1, 2) returns bits 16k+15:16k of the filter entry selected by index 14 (entry select, low 4 bits kept), but only in reset mode. Outside reset mode these indices read 0.
- R8: A command write drives act, one cycle later and for one cycle, with the data ANDed with 0x03BF. Bit meanings: 0 halt transmit, 1 transmit, 2 receiver disable, 3 receiver enable, 4 timer stop, 5 timer start, 7 software reset, 8 resource read, 9 load filter. In reset mode, a command write with bit 7 clear only clears bit 7 and issues no pulse. With no write, act is 0.
- R9: Written command bits are ORed into the command register, except bit 8, which never stays set. Receiver enable clears bit 2, and receiver disable without enable clears bit 3. Timer start clears bit 4, and timer stop without start clears bit 5.
- R10: A software reset command clears command bits 0, 1, 8 and 9 and sets bits 7 and 2.
- R11: A resource read advances the read pointer by 8, or by 16 in 32-bit width. If the result equals the resource end, the pointer becomes the resource start. If the final pointer equals the write pointer, status bit 5 (buffers exhausted) is set.
- R12: A status write that clears a set bit 5 issues a resource read, which pulses act bit 8 and performs the R11 update. Writing a one to an already clear bit 5 issues nothing.
- R13: Indices 20 to 31 store the full written value. rd_data loads the selected register one cycle after rd_en and holds its value while rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_idx | input | 5 | Register index for read or write |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 16 | Registered read data |
| stat_set | input | 16 | Status set events from the datapaths |
| filt_wr_en | input | 1 | Filter entry load strobe |
| filt_wr_idx | input | 4 | Filter entry to load |
| filt_wr_data | input | 48 | Filter entry value |
| act | output | 16 | One-cycle action pulses, command bit positions |
| irq | output | 1 | Interrupt request |

## Verification
Every register update, act pulse and status change becomes visible at the first clock edge after the write strobe, and irq follows in that same cycle because it is decoded from the stored registers. Read data arrives one edge after rd_en. The bench therefore drives strobes on the falling edge, removes them on the next falling edge, and samples act, irq and the register contents at that second falling edge. It issues a read strobe and compares rd_data one falling edge later. Resource-read side effects are checked by reading back the read pointer and status after the pulse edge.

// File: rtl/enet_regbank.sv
module enet_regbank #(
  parameter int NREG  = 32,
  parameter int NFILT = 16,
  localparam int AW = $clog2(NREG),
  localparam int FW = $clog2(NFILT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_idx,
  input  logic          wr_en,
  input  logic [15:0]   wr_data,
  input  logic          rd_en,
  output logic [15:0]   rd_data,
  input  logic [15:0]   stat_set,
  input  logic          filt_wr_en,
  input  logic [FW-1:0] filt_wr_idx,
  input  logic [47:0]   filt_wr_data,
  output logic [15:0]   act,
  output logic          irq
);
  localparam logic [AW-1:0] I_CMD = AW'(0), I_DCFG = AW'(1), I_DCFG2 = AW'(2),
    I_RXC = AW'(3), I_TXC = AW'(4), I_IMASK = AW'(5), I_ISTAT = AW'(6),
    I_RSA = AW'(7), I_REA = AW'(8), I_RRP = AW'(9), I_RWP = AW'(10),
    I_CRC = AW'(11), I_FAE = AW'(12), I_MPT = AW'(13), I_SEL = AW'(14),
    I_AP0 = AW'(15), I_AP1 = AW'(16), I_AP2 = AW'(17), I_REV = AW'(18),
    I_MDT = AW'(19);
  localparam int GEN_BASE = 20;
  localparam logic [15:0] CMD_MASK = 16'h03BF;
  localparam logic [15:0] CMD_RST_VAL = 16'h0094;
  localparam logic [15:0] REV_VAL = 16'h0004;
  localparam int RBE = 5;

  logic [15:0] cmd_q, dcfg_q, dcfg2_q, rxc_q, txc_q, imask_q, istat_q;
  logic [15:0] rsa_q, rea_q, rrp_q, rwp_q, crc_q, fae_q, mpt_q;
  logic [FW-1:0] sel_q;
  logic [47:0] filt_q [NFILT];
  logic [15:0] gen_q [NREG];

  wire in_rst = cmd_q[7];
  wire wc = wr_en && reg_idx == I_CMD;
  wire leave = wc && in_rst && !wr_data[7];
  wire issue = wc && !leave;
  wire [15:0] cbits = wr_data & CMD_MASK;
  wire [15:0] clr = (wr_en && reg_idx == I_ISTAT) ? (wr_data & istat_q) : 16'h0;
  wire rsrc_go = (issue && cbits[8]) || clr[RBE];
  wire [15:0] pmask = dcfg_q[5] ? 16'hFFFC : 16'hFFFE;
  wire [15:0] step = dcfg_q[5] ? 16'd16 : 16'd8;
  wire [15:0] rrp_adv = rrp_q + step;
  wire [15:0] rrp_nx = (rrp_adv == rea_q) ? rsa_q : rrp_adv;
  wire rbe_set = rsrc_go && rrp_nx == rwp_q;

  function automatic logic [15:0] cmd_update(input logic [15:0] cur, input logic [15:0] b);
    logic [15:0] c;
    c = cur | (b & ~16'h0100);
    if (b[2] && !b[3]) c[3] = 1'b0;
    if (b[3]) c[2] = 1'b0;
    if (b[4] && !b[5]) c[5] = 1'b0;
    if (b[5]) c[4] = 1'b0;
    if (b[7]) begin
      c[0] = 1'b0; c[1] = 1'b0; c[8] = 1'b0; c[9] = 1'b0;
      c[7] = 1'b1; c[2] = 1'b1;
    end
    return c;
  endfunction

  function automatic logic wr_to(input logic [AW-1:0] i);
    return wr_en && reg_idx == i;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= CMD_RST_VAL;
      act   <= '0;
    end else begin
      if (leave) cmd_q <= cmd_q & ~16'h0080;
      else if (issue) cmd_q <= cmd_update(cmd_q, cbits);
      act <= (issue ? cbits : 16'h0) | (clr[RBE] ? 16'h0100 : 16'h0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dcfg_q <= '0; dcfg2_q <= '0; rxc_q <= '0; txc_q <= '0; imask_q <= '0;
      crc_q <= '0; fae_q <= '0; mpt_q <= '0; sel_q <= '0;
    end else begin
      if (wr_to(I_DCFG) && in_rst)  dcfg_q  <= wr_data & 16'hBFFF;
      if (wr_to(I_DCFG2) && in_rst) dcfg2_q <= wr_data & 16'hF017;
      if (wr_to(I_RXC))   rxc_q   <= wr_data & 16'hFFE0;
      if (wr_to(I_TXC))   txc_q   <= wr_data & 16'hF000;
      if (wr_to(I_IMASK)) imask_q <= wr_data & 16'h7FFF;
      if (wr_to(I_CRC))   crc_q   <= ~wr_data;
      if (wr_to(I_FAE))   fae_q   <= ~wr_data;
      if (wr_to(I_MPT))   mpt_q   <= ~wr_data;
      if (wr_to(I_SEL))   sel_q   <= wr_data[FW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      istat_q <= '0;
      rsa_q <= '0; rea_q <= '0; rrp_q <= '0; rwp_q <= '0;
    end else begin
      istat_q <= (istat_q & ~clr) | (stat_set & 16'h7FFF) | (16'(rbe_set) << RBE);
      if (wr_to(I_RSA)) rsa_q <= wr_data & pmask;
      if (wr_to(I_REA)) rea_q <= wr_data & pmask;
      if (wr_to(I_RWP)) rwp_q <= wr_data & pmask;
      if (rsrc_go) rrp_q <= rrp_nx;
      else if (wr_to(I_RRP)) rrp_q <= wr_data & pmask;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int g = 0; g < NREG; g++) gen_q[g] <= '0;
      for (int f = 0; f < NFILT; f++) filt_q[f] <= '0;
    end else begin
      for (int g = GEN_BASE; g < NREG; g++)
        if (wr_en && reg_idx == AW'(g)) gen_q[g] <= wr_data;
      if (filt_wr_en) filt_q[filt_wr_idx] <= filt_wr_data;
    end
  end

  wire [47:0] ent = filt_q[sel_q];
  logic [15:0] rmux;

  always_comb begin
    case (reg_idx)
      I_CMD:   rmux = cmd_q;
      I_DCFG:  rmux = dcfg_q;
      I_DCFG2: rmux = dcfg2_q;
      I_RXC:   rmux = rxc_q;
      I_TXC:   rmux = txc_q;
      I_IMASK: rmux = imask_q;
      I_ISTAT: rmux = istat_q;
      I_RSA:   rmux = rsa_q;
      I_REA:   rmux = rea_q;
      I_RRP:   rmux = rrp_q;
      I_RWP:   rmux = rwp_q;
      I_CRC:   rmux = crc_q;
      I_FAE:   rmux = fae_q;
      I_MPT:   rmux = mpt_q;
      I_SEL:   rmux = 16'(sel_q);
      I_AP0:   rmux = in_rst ? ent[15:0]  : 16'h0;
      I_AP1:   rmux = in_rst ? ent[31:16] : 16'h0;
      I_AP2:   rmux = in_rst ? ent[47:32] : 16'h0;
      I_REV:   rmux = REV_VAL;
      I_MDT:   rmux = 16'h0;
      default: rmux = gen_q[reg_idx];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= '0;
    else if (rd_en) rd_data <= rmux;
  end

  assign irq = |(istat_q & imask_q);
endmodule

// File: rtl/enet_regbank_chk.sv
module enet_regbank_chk #(
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] reg_idx,
  input logic          wr_en,
  input logic [15:0]   wr_data,
  input logic          rd_en,
  input logic [15:0]   rd_data,
  input logic [15:0]   stat_set,
  input logic [15:0]   act,
  input logic          irq,
  input logic [15:0]   cmd_q,
  input logic [15:0]   dcfg_q,
  input logic [15:0]   imask_q,
  input logic [15:0]   istat_q,
  input logic [15:0]   crc_q
);
  a_r2_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_idx == AW'(1) && !cmd_q[7]) |=> $stable(dcfg_q));

  a_r4_irq_on_enabled_set: assert property (@(posedge clk) disable iff (!rst_n)
    (((stat_set & imask_q & 16'h7FFF) != 16'h0) && !(wr_en && reg_idx == AW'(5))) |=> irq);

  a_r4_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_idx == AW'(6) && stat_set == 16'h0) |=> ((istat_q & $past(wr_data) & 16'hFFDF) == 16'h0));

  a_r6_tally_inverts: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_idx == AW'(11)) |=> (crc_q == ~$past(wr_data)));

  a_r8_no_write_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (act == 16'h0));

  a_r9_rsrc_bit_never_held: assert property (@(posedge clk) disable iff (!rst_n)
    wc_any() |=> !cmd_q[8]);

  a_r10_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_idx == AW'(0) && wr_data[7]) |=> (cmd_q[7] && cmd_q[2] && !cmd_q[0] && !cmd_q[1] && !cmd_q[9]));

  a_r7_revision_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && reg_idx == AW'(18)) |=> (rd_data == 16'h0004));

  function automatic logic wc_any();
    return wr_en && reg_idx == AW'(0);
  endfunction
endmodule

bind enet_regbank enet_regbank_chk #(.AW(AW)) u_chk (.*);

// File: tb/enet_regbank_tb.sv
`timescale 1ns/1ps
module enet_regbank_tb;
  logic clk = 0, rst_n = 0;
  logic [4:0] reg_idx = '0;
  logic wr_en = 0, rd_en = 0, filt_wr_en = 0;
  logic [15:0] wr_data = '0, stat_set = '0;
  logic [3:0] filt_wr_idx = '0;
  logic [47:0] filt_wr_data = '0;
  logic [15:0] rd_data, act;
  logic irq;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  enet_regbank u_dut (
    .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .stat_set(stat_set), .filt_wr_en(filt_wr_en),
    .filt_wr_idx(filt_wr_idx), .filt_wr_data(filt_wr_data), .act(act), .irq(irq)
  );

  task automatic chk(input string r, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", r, got, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [15:0] d);
    @(negedge clk); reg_idx = 5'(idx); wr_data = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic wr_set(input int idx, input logic [15:0] d, input logic [15:0] s);
    @(negedge clk); reg_idx = 5'(idx); wr_data = d; wr_en = 1; stat_set = s;
    @(negedge clk); wr_en = 0; stat_set = '0;
  endtask

  task automatic rd(input int idx, output logic [15:0] v);
    @(negedge clk); reg_idx = 5'(idx); rd_en = 1;
    @(negedge clk); rd_en = 0; v = rd_data;
  endtask

  task automatic rchk(input string r, input int idx, input logic [15:0] exp);
    logic [15:0] v;
    rd(idx, v);
    chk(r, v, exp);
  endtask

  task automatic pulse_set(input logic [15:0] s);
    @(negedge clk); stat_set = s;
    @(negedge clk); stat_set = '0;
  endtask

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 irq", {15'h0, irq}, 16'h0);
    rchk("R1 cmd", 0, 16'h0094);
    rchk("R1 rev", 18, 16'h0004);
    rchk("R1 imask", 5, 16'h0000);
    rchk("R1 istat", 6, 16'h0000);
    rchk("R1 general", 20, 16'h0000);

    // R2 writable in reset mode
    for (int i = 0; i < 64; i++) begin
      logic [15:0] d;
      d = 16'(i * 16'h0411) ^ 16'hA5C3;
      wr(2, d);
      rchk("R2 cfg2 masked", 2, d & 16'hF017);
    end
    wr(1, 16'hFFFF);
    rchk("R2 cfg masked", 1, 16'hBFFF);

    // R8 leave reset mode: no pulse
    wr(0, 16'h0000);
    chk("R8 leave no pulse", act, 16'h0000);
    rchk("R8 leave cmd", 0, 16'h0014);
    wr(1, 16'h0000);
    rchk("R2 cfg locked", 1, 16'hBFFF);
    wr(2, 16'h0000);
    rchk("R2 cfg2 locked", 2, 16'hF017 & (16'(63 * 16'h0411) ^ 16'hA5C3));

    // R3 R6 R13 sweeps
    for (int i = 0; i < 256; i++) begin
      logic [15:0] d;
      d = {i[7:0], ~i[7:0]} ^ 16'h3C96;
      wr(3, d);  rchk("R3 rxctl", 3, d & 16'hFFE0);
      wr(4, d);  rchk("R3 txctl", 4, d & 16'hF000);
      wr(5, d);  rchk("R3 imask", 5, d & 16'h7FFF);
      wr(11, d); rchk("R6 crc tally", 11, ~d);
      wr(12, d); rchk("R6 align tally", 12, ~d);
      wr(13, d); rchk("R6 miss tally", 13, ~d);
      wr(20 + (i % 12), d); rchk("R13 general", 20 + (i % 12), d);
    end
    wr(5, 16'h0000);
    rd(20, v);
    @(negedge clk); @(negedge clk);
    chk("R13 rd held", rd_data, v);

    // R5 wide pointers
    wr(7, 16'h0107);
    rchk("R5 wide mask", 7, 16'h0104);

    // R7 read-only outside reset
    wr(18, 16'hFFFF); rchk("R7 rev ro", 18, 16'h0004);
    wr(19, 16'hFFFF); rchk("R7 mdt ro", 19, 16'h0000);
    wr(15, 16'hFFFF); rchk("R7 port ro", 15, 16'h0000);

    // filter entries
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      filt_wr_en = 1; filt_wr_idx = 4'(k);
      filt_wr_data = {16'hA000 | 16'(k), 16'hB000 | 16'(k), 16'hC000 | 16'(k)};
      @(negedge clk); filt_wr_en = 0;
    end

    // R8 R10 commands
    wr(0, 16'h0003);
    chk("R8 pulse tx", act, 16'h0003);
    wr(0, 16'h0200);
    chk("R8 pulse load", act, 16'h0200);
    rchk("R9 cmd held", 0, 16'h0217);
    wr(0, 16'h0080);
    chk("R8 pulse reset", act, 16'h0080);
    rchk("R10 soft reset", 0, 16'h0094);

    // R7 ports in reset mode
    for (int k = 0; k < 16; k++) begin
      wr(14, 16'(k));
      rchk("R7 port0", 15, 16'hC000 | 16'(k));
      rchk("R7 port1", 16, 16'hB000 | 16'(k));
      rchk("R7 port2", 17, 16'hA000 | 16'(k));
    end
    wr(16, 16'h0000);
    rchk("R7 port write ignored", 16, 16'hB00F);

    wr(1, 16'h0000);
    wr(7, 16'h0103);
    rchk("R5 narrow mask", 7, 16'h0102);
    wr(0, 16'h0000);
    rchk("R7 port out of reset", 15, 16'h0000);

    // R9 exclusive bits
    wr(0, 16'h0008); chk("R8 rxen pulse", act, 16'h0008);
    rchk("R9 rxen", 0, 16'h0018);
    chk("R8 idle no pulse", act, 16'h0000);
    wr(0, 16'h000C); rchk("R9 both rx", 0, 16'h0018);
    wr(0, 16'h0020); rchk("R9 start", 0, 16'h0028);
    wr(0, 16'h0004); rchk("R9 rxdis", 0, 16'h0024);
    wr(0, 16'h0010); rchk("R9 stop", 0, 16'h0014);

    // R11 resource read, narrow
    wr(7, 16'h0100); wr(8, 16'h0120); wr(9, 16'h0110); wr(10, 16'h0100);
    wr(0, 16'h0100);
    chk("R8 rsrc pulse", act, 16'h0100);
    rchk("R9 rsrc not held", 0, 16'h0014);
    rchk("R11 advance", 9, 16'h0118);
    rchk("R11 no rbe", 6, 16'h0000);
    wr(0, 16'h0100);
    rchk("R11 wrap", 9, 16'h0100);
    rchk("R11 rbe set", 6, 16'h0020);
    wr(5, 16'h0020);
    chk("R4 irq on", {15'h0, irq}, 16'h0001);

    // R12
    wr(6, 16'h0020);
    chk("R12 pulse", act, 16'h0100);
    chk("R4 irq off", {15'h0, irq}, 16'h0000);
    rchk("R12 advance", 9, 16'h0108);
    rchk("R12 status", 6, 16'h0000);
    wr(6, 16'h0020);
    chk("R12 clear bit no pulse", act, 16'h0000);
    rchk("R12 no advance", 9, 16'h0108);

    // R4 status
    pulse_set(16'hFFFF);
    rchk("R4 set bit15 ignored", 6, 16'h7FFF);
    chk("R4 irq", {15'h0, irq}, 16'h0001);
    wr(6, 16'h00FF);
    chk("R12 pulse via mixed clear", act, 16'h0100);
    rchk("R4 w1c", 6, 16'h7F00);
    rchk("R12 advance2", 9, 16'h0110);
    chk("R4 irq masked", {15'h0, irq}, 16'h0000);
    wr(5, 16'h0100);
    chk("R4 irq by mask", {15'h0, irq}, 16'h0001);
    wr_set(6, 16'h0100, 16'h0100);
    rchk("R4 set wins", 6, 16'h7F00);

    // R11 wide step
    wr(0, 16'h0080);
    wr(1, 16'h0020);
    wr(0, 16'h0000);
    wr(0, 16'h0100);
    rchk("R11 wide wrap", 9, 16'h0100);
    rchk("R11 wide rbe", 6, 16'h7F20);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule